// File: doc/BRIEF.md
# Selectable-Period Twelve-Phase Digital PWM

This block is a counter-driven pulse width modulator for a multi-phase switching converter. It drives twelve interleaved PWM lines from one fast clock. A single free-running period counter sets the switching period. Each of the twelve lines starts its on-time at its own fixed fraction of that period. A frequency-select input picks one of five period lengths. Every halving of the period costs one bit of duty resolution, so resolution runs from 11 bits at the longest period down to 7 bits at the shortest.

The duty command is always 11 bits wide and MSB-aligned. At coarser settings its low-order bits are dropped. Duty and frequency changes are taken only on a period boundary, so a running period always completes and the twelve phases keep their spacing, whatever the setting. A one-cycle strobe marks the start of each period, and it is aligned with the rising edge of phase 0.

Top module: `mpmf_dpwm`

## Requirements
- R1: While reset is asserted, every PWM line and the strobe are low. The first period after reset lasts 2048 cycles with zero effective duty, whatever the inputs are.
- R2: The frequency select maps code 0, 1, 2, 3 and 4 to periods of 2048, 1024, 512, 256 and 128 clock cycles (N = 11 − code). Codes 5 to 7 act as code 4.
- R3: The strobe is high for exactly one cycle per period. Strobes are spaced exactly one period apart.
- R4: The effective duty is the 11-bit command shifted right by the select code, so only its top N bits are used.
- R5: Phase k (0..11) goes high floor(k·P/12) cycles after the strobe cycle, where P is the period. Phase 0 rises in the strobe cycle itself.
- R6: Within each period, every phase is high for exactly the effective duty count of cycles. An on-time that runs past the period end wraps to the period start.
- R7: An effective duty of zero holds every line low. The all-ones command holds each line high for P−1 cycles per period.
- R8: A change to the duty command or the select in mid-period has no effect until the next period start. The running period keeps its old length and duty.
- R9: In the first period after a change of select, every phase already rises at its offset for the new period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast modulator clock |
| rst | input | 1 | Synchronous active-high reset |
| duty_cmd | input | 11 | MSB-aligned duty command |
| freq_sel | input | 3 | Period select code (0 = longest) |
| pwm_o | output | 12 | Interleaved PWM phase lines, bit k = phase k |
| period_start_o | output | 1 | One-cycle period-start strobe |

## Verification
The hardest case to reach is a select change that lands in the middle of a running period. The old setting must then finish its full length, and the new offsets must take effect cleanly at the next boundary. The stimulus counts cycles from a strobe and changes both inputs partway through a short period. It then measures that period's length and phase-0 on-time, and afterwards the rise point of every phase in the following, longer period. A second switch, from a mid setting to the longest period, catches phases whose wrapped on-time starts the new window high. A cycle-level reference model runs alongside the directed measurements.

// File: rtl/mpmf_dpwm_pkg.sv
package mpmf_dpwm_pkg;

    localparam int RES_MAX = 11;
    localparam int N_SET   = 5;
    localparam int N_PH    = 12;
    localparam int SEL_W   = 3;

    typedef logic [RES_MAX-1:0] count_t;
    typedef logic [SEL_W-1:0]   sel_t;

    typedef struct packed {
        sel_t   sel;
        count_t duty;
    } setting_t;

    function automatic sel_t clamp_sel(input sel_t s);
        return (s > sel_t'(N_SET - 1)) ? sel_t'(N_SET - 1) : s;
    endfunction

    function automatic count_t period_mask(input sel_t s);
        count_t m;
        m = '1;
        return m >> s;
    endfunction

    function automatic count_t trunc_duty(input count_t d, input sel_t s);
        return d >> s;
    endfunction

    function automatic count_t phase_start(input int k, input int s);
        int p;
        p = 1 << (RES_MAX - s);
        return count_t'((k * p) / N_PH);
    endfunction

endpackage

// File: rtl/dpwm_period_ctr.sv
module dpwm_period_ctr
    import mpmf_dpwm_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  count_t   duty_cmd,
    input  sel_t     freq_sel,
    output count_t   cnt_o,
    output setting_t act_o
);

    count_t   cnt_q;
    setting_t act_q;
    logic     wrap;
    sel_t     nsel;

    always_comb begin
        wrap = (cnt_q == period_mask(act_q.sel));
        nsel = clamp_sel(freq_sel);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q      <= '0;
            act_q.sel  <= '0;
            act_q.duty <= '0;
        end else if (wrap) begin
            cnt_q      <= '0;
            act_q.sel  <= nsel;
            act_q.duty <= trunc_duty(duty_cmd, nsel);
        end else begin
            cnt_q <= cnt_q + count_t'(1);
        end
    end

    assign cnt_o = cnt_q;
    assign act_o = act_q;

endmodule

// File: rtl/dpwm_phase_table.sv
module dpwm_phase_table
    import mpmf_dpwm_pkg::*;
#(
    parameter int PHASES   = N_PH,
    parameter int SETTINGS = N_SET
) (
    input  sel_t                             sel,
    output logic [PHASES-1:0][RES_MAX-1:0]   off_o
);

    logic [SETTINGS-1:0][PHASES-1:0][RES_MAX-1:0] tbl;

    for (genvar s = 0; s < SETTINGS; s++) begin : g_set
        for (genvar k = 0; k < PHASES; k++) begin : g_ph
            assign tbl[s][k] = phase_start(k, s);
        end
    end

    always_comb begin
        off_o = tbl[0];
        for (int s = 1; s < SETTINGS; s++) begin
            if (sel == sel_t'(s)) off_o = tbl[s];
        end
    end

endmodule

// File: rtl/dpwm_phase_bank.sv
module dpwm_phase_bank
    import mpmf_dpwm_pkg::*;
#(
    parameter int PHASES = N_PH
) (
    input  logic                           clk,
    input  logic                           rst,
    input  count_t                         cnt,
    input  setting_t                       act,
    input  logic [PHASES-1:0][RES_MAX-1:0] off,
    output logic [PHASES-1:0]              pwm_o,
    output logic                           strobe_o
);

    count_t mask;
    assign mask = period_mask(act.sel);

    for (genvar k = 0; k < PHASES; k++) begin : g_lane
        count_t diff;
        logic   on_now;
        always_comb begin
            diff   = (cnt - off[k]) & mask;
            on_now = (diff < act.duty);
        end
        always_ff @(posedge clk) begin
            if (rst) pwm_o[k] <= 1'b0;
            else     pwm_o[k] <= on_now;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) strobe_o <= 1'b0;
        else     strobe_o <= (cnt == '0);
    end

endmodule

// File: rtl/mpmf_dpwm.sv
module mpmf_dpwm
    import mpmf_dpwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [10:0]       duty_cmd,
    input  logic [2:0]        freq_sel,
    output logic [11:0]       pwm_o,
    output logic              period_start_o
);

    count_t                        cnt;
    setting_t                      act;
    logic [N_PH-1:0][RES_MAX-1:0]  off;

    dpwm_period_ctr u_ctr (
        .clk      (clk),
        .rst      (rst),
        .duty_cmd (duty_cmd),
        .freq_sel (freq_sel),
        .cnt_o    (cnt),
        .act_o    (act)
    );

    dpwm_phase_table #(.PHASES(N_PH), .SETTINGS(N_SET)) u_tbl (
        .sel   (act.sel),
        .off_o (off)
    );

    dpwm_phase_bank #(.PHASES(N_PH)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .cnt      (cnt),
        .act      (act),
        .off      (off),
        .pwm_o    (pwm_o),
        .strobe_o (period_start_o)
    );

endmodule

// File: rtl/dpwm_checker.sv
module dpwm_checker
    import mpmf_dpwm_pkg::*;
(
    input logic         clk,
    input logic         rst,
    input logic [11:0]  pwm,
    input logic         strobe,
    input count_t       cnt,
    input sel_t         act_sel,
    input count_t       act_duty
);

    logic [RES_MAX:0] gap;

    always_ff @(posedge clk) begin
        if (rst || strobe) gap <= '0;
        else               gap <= gap + 1'b1;
    end

    // R1: state right after reset release
    a_r1_start_state: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (cnt == '0 && act_sel == '0 && act_duty == '0 && pwm == '0));

    // R2: counter never passes the active period end
    a_r2_count_in_range: assert property (@(posedge clk) disable iff (rst)
        cnt <= period_mask(act_sel));

    // R3: strobe follows a zero count
    a_r3_strobe_on_zero: assert property (@(posedge clk) disable iff (rst)
        strobe |-> $past(cnt) == '0);

    a_r3_zero_gives_strobe: assert property (@(posedge clk) disable iff (rst)
        (cnt == '0) |=> strobe);

    a_r3_strobe_gap: assert property (@(posedge clk) disable iff (rst)
        gap < (1 << RES_MAX));

    // R7: zero effective duty keeps every line low
    a_r7_zero_duty_low: assert property (@(posedge clk) disable iff (rst)
        (act_duty == '0) |=> (pwm == '0));

    // R8: setting only moves on a period boundary
    a_r8_setting_hold: assert property (@(posedge clk) disable iff (rst)
        (cnt != '0) |-> $stable({act_sel, act_duty}));

endmodule

bind mpmf_dpwm dpwm_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .pwm      (pwm_o),
    .strobe   (period_start_o),
    .cnt      (cnt),
    .act_sel  (act.sel),
    .act_duty (act.duty)
);

// File: tb/sim_mpmf_dpwm.sv
`timescale 1ns/1ps
module sim_mpmf_dpwm;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [10:0] duty = '0;
    logic [2:0]  fsel = '0;
    logic [11:0] pwm;
    logic        strobe;

    always #10 clk = ~clk;

    mpmf_dpwm u0 (
        .clk            (clk),
        .rst            (rst),
        .duty_cmd       (duty),
        .freq_sel       (fsel),
        .pwm_o          (pwm),
        .period_start_o (strobe)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // cycle-level reference model built from the requirements
    int          m_cnt, m_sel, m_duty;
    logic [11:0] m_pwm;
    logic        m_str;

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_sel = 0; m_duty = 0; m_pwm = '0; m_str = 1'b0;
        end else begin
            int p;
            p = 2048 >> m_sel;
            for (int k = 0; k < 12; k++) begin
                int s;
                s = (k * p) / 12;
                m_pwm[k] = (((m_cnt - s + p) % p) < m_duty);
            end
            m_str = (m_cnt == 0);
            if (m_cnt == p - 1) begin
                m_cnt  = 0;
                m_sel  = (int'(fsel) > 4) ? 4 : int'(fsel);
                m_duty = int'(duty) >> m_sel;
            end else begin
                m_cnt++;
            end
        end
    end

    logic [11:0] lastp = '0;
    int r_per, r_mbad;
    int r_rise [12];
    int r_high [12];

    task automatic wait_strobe();
        forever begin
            @(negedge clk);
            if (strobe) break;
            lastp = pwm;
        end
    endtask

    // called at a strobe negedge; measures one period
    task automatic measure(input int chg_at, input int nsel, input int nduty);
        int i;
        i = 0;
        r_mbad = 0;
        for (int k = 0; k < 12; k++) begin r_rise[k] = -1; r_high[k] = 0; end
        forever begin
            if (i == chg_at) begin fsel = 3'(nsel); duty = 11'(nduty); end
            if (pwm !== m_pwm || strobe !== m_str) r_mbad++;
            for (int k = 0; k < 12; k++) begin
                if (pwm[k] && !lastp[k] && r_rise[k] < 0 && (i > 0 || k == 0)) r_rise[k] = i;
                if (pwm[k]) r_high[k]++;
            end
            lastp = pwm;
            @(negedge clk);
            i++;
            if (strobe) break;
            if (i > 4096) break;
        end
        r_per = i;
    endtask

    task automatic t_reset();
        rst = 1'b1; duty = 11'h555; fsel = 3'd4;
        repeat (3) begin
            @(negedge clk);
            chk(pwm == '0 && strobe == 1'b0, "R1 reset outputs", int'(pwm), 0);
        end
        rst = 1'b0;
        wait_strobe();
        measure(-1, 0, 0);
        chk(r_per == 2048, "R1 first period length", r_per, 2048);
        for (int k = 0; k < 12; k++)
            chk(r_high[k] == 0, "R1 first period zero duty", r_high[k], 0);
        chk(r_mbad == 0, "R6 model match", r_mbad, 0);
    endtask

    task automatic t_setting(input int sel, input int dcode);
        int cs, p, d;
        cs = (sel > 4) ? 4 : sel;
        p  = 2048 >> cs;
        d  = dcode >> cs;
        fsel = 3'(sel); duty = 11'(dcode);
        wait_strobe();
        wait_strobe();
        measure(-1, 0, 0);
        chk(r_per == p, "R2 period length", r_per, p);
        chk(r_high[0] == d, "R4 truncated duty", r_high[0], d);
        for (int k = 1; k < 12; k++)
            chk(r_high[k] == d, "R6 per-phase on-time", r_high[k], d);
        if (d > 0) begin
            chk(r_rise[0] == 0, "R5 phase 0 with strobe", r_rise[0], 0);
            chk(r_rise[7] == (7 * p) / 12, "R5 phase 7 offset", r_rise[7], (7 * p) / 12);
            chk(r_rise[11] == (11 * p) / 12, "R5 phase 11 offset", r_rise[11], (11 * p) / 12);
        end else begin
            chk(r_rise[3] == -1, "R7 zero duty never rises", r_rise[3], -1);
        end
        chk(r_mbad == 0, "R6 model match", r_mbad, 0);
    endtask

    task automatic t_midchange();
        fsel = 3'd4; duty = 11'h555;
        wait_strobe();
        wait_strobe();
        measure(40, 2, 11'h200);
        chk(r_per == 128, "R8 running period kept", r_per, 128);
        chk(r_high[0] == 85, "R8 running duty kept", r_high[0], 85);
        chk(r_mbad == 0, "R8 model match", r_mbad, 0);
        measure(-1, 0, 0);
        chk(r_per == 512, "R8 new period applied", r_per, 512);
        for (int k = 0; k < 12; k++)
            chk(r_rise[k] == (k * 512) / 12, "R9 offsets after up-switch", r_rise[k], (k * 512) / 12);
        chk(r_mbad == 0, "R9 model match", r_mbad, 0);
    endtask

    task automatic t_downswitch();
        fsel = 3'd0; duty = 11'h400;
        wait_strobe();
        measure(-1, 0, 0);
        chk(r_per == 2048, "R9 longest period after switch", r_per, 2048);
        for (int k = 0; k < 12; k++)
            chk(r_rise[k] == (k * 2048) / 12, "R9 offsets after down-switch", r_rise[k], (k * 2048) / 12);
        chk(r_mbad == 0, "R9 model match", r_mbad, 0);
    endtask

    initial begin : watchdog
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        t_reset();
        for (int s = 0; s < 5; s++) t_setting(s, 11'h555);   // R2 R4 R5 R6
        t_setting(6, 11'h7FF);                                // R2 clamp, R7 max
        t_setting(0, 11'h7FF);                                // R7 max at 11 bits
        t_setting(3, 0);                                      // R7 zero
        t_setting(2, 11'h00F);                                // R4 low bits dropped -> 3
        t_midchange();                                        // R8 R9
        t_downswitch();                                       // R9
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule